// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block sits between a motor controller's PWM outputs and the gate drivers of two independent half-bridge phases. For each phase it accepts a top-switch command and a bottom-switch command and turns them into two gate-enable outputs, so that every phase is in one of three conditions: top switch on, bottom switch on, or both off (output high-impedance). It never lets both switches of a phase conduct together. When the two commands of a phase swap in the same cycle, it holds both switches off for a fixed number of clock cycles before the newly commanded one turns on.

Two global disable inputs force all four switches off. The first disable line has three levels: left floating, driven low, or driven high. Driven high, it disables the outputs. Left floating, it allows a cycle-by-cycle current limit to run: a per-phase over-threshold flag engages a latch that turns off that phase's top switch until the top command rises again. Driven low, it turns the current limit off. The state of the latches is reported on a single output. Every input passes through a two-stage synchronizer. Each phase is run by a four-state machine: OFF, TOP_ON, BOT_ON and DEAD. The transitions are:
- OFF goes to TOP_ON or BOT_ON when that switch's command is the one in effect.
- TOP_ON goes to BOT_ON only by way of DEAD; it goes straight to OFF.
- BOT_ON goes to TOP_ON only by way of DEAD; it goes straight to OFF.
- DEAD leaves, after its count, to whatever state the commands then ask for.

Top module: `hbg_gate_ctrl`

## Requirements
- R1: An input change reaches the gate outputs after the third rising clock edge that follows it. A top-only command (top 1, bottom 0) turns on only that phase's top gate. A bottom-only command turns on only its bottom gate.
- R2: When a phase's top and bottom commands are both 1, both gates of that phase are 0.
- R3: When a phase's top and bottom commands are both 0, both gates of that phase are 0.
- R4: If a phase goes straight from TOP_ON to a bottom-only command, or from BOT_ON to a top-only command, both of its gates stay 0 for exactly DEAD_CYC cycles (default 8) before the new gate turns on. If the commands pass through a both-low cycle instead, no dead interval is added.
- R5: While `dis2` is 1, all four gates are 0. Tying `dis2` to 0 acts as the unconnected default and has no effect.
- R6: `dis1_mode` is encoded as 2'b00 for floating (current limit active), 2'b01 for driven low (current limit off), and 2'b10 or 2'b11 for driven high. Driven high forces all four gates to 0 and clears the latches.
- R7: With `dis1_mode` at 2'b00, an `oc_flag[i]` pulse engages phase i's latch. That phase's top gate turns off and `cl_engaged` goes to 1. The other phase and all bottom gates are unaffected.
- R8: An engaged latch clears on the next rising edge of its phase's synchronized top command. The top gate then turns on with no extra delay. If the flag is 1 in the same cycle as that edge, the latch stays engaged.
- R9: With `dis1_mode` at 2'b01, `oc_flag` is ignored and any engaged latch clears, so `cl_engaged` is 0 and the top gates follow their commands.
- R10: During reset all gates and `cl_engaged` are 0.
- R11: The top and bottom gates of a phase are never 1 in the same cycle, and neither gate turns on in the cycle right after the other was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_cmd | input | 2 | Top-switch command per phase, 1 = on |
| bot_cmd | input | 2 | Bottom-switch command per phase, 1 = on |
| oc_flag | input | 2 | Over-threshold flag per phase |
| dis1_mode | input | 2 | Level of the first disable / current-limit line (00 float, 01 low, 1x high) |
| dis2 | input | 1 | Second disable, 1 = all switches off |
| gate_top | output | 2 | Top gate enable per phase |
| gate_bot | output | 2 | Bottom gate enable per phase |
| cl_engaged | output | 1 | 1 while any current-limit latch is engaged |

## Verification
Two pairs of events can fall in the same clock cycle. First, a phase's top command can rise in the very cycle its over-threshold flag is raised, which sets the latch and clears it at once. Second, a simultaneous top/bottom swap can arrive together with a disable. The bench provokes both by changing the inputs at the same falling edge. A behavioural model with its own counters decides the expected gate levels, and these are compared with the outputs on every clock. Dead-interval length and the three-edge latency are also counted explicitly, measured from the moment the swap is applied.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_TOP  = 2'd1,
        PH_BOT  = 2'd2,
        PH_DEAD = 2'd3
    } ph_state_e;

    localparam logic [1:0] DIS1_FLOAT = 2'b00;
    localparam logic [1:0] DIS1_LOW   = 2'b01;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_cl_latch.sv
module hbg_cl_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cl_en,
    input  logic oc_s,
    input  logic top_s,
    output logic latched,
    output logic limit_eff
);
    logic top_d;
    logic top_rise;

    assign top_rise = top_s & ~top_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_d   <= 1'b0;
            latched <= 1'b0;
        end else begin
            top_d <= top_s;
            if (!cl_en)        latched <= 1'b0;
            else if (oc_s)     latched <= 1'b1;
            else if (top_rise) latched <= 1'b0;
        end
    end

    // a fresh top edge releases the limit in the same cycle it clears the latch
    assign limit_eff = latched & ~top_rise;
endmodule

// File: rtl/hbg_phase_fsm.sv
module hbg_phase_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic top_s,
    input  logic bot_s,
    input  logic dis,
    input  logic limit,
    output logic gate_top,
    output logic gate_bot
);
    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);

    ph_state_e st_q, st_d, tgt;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (dis || (top_s && bot_s)) tgt = PH_OFF;
        else if (top_s)              tgt = limit ? PH_OFF : PH_TOP;
        else if (bot_s)              tgt = PH_BOT;
        else                         tgt = PH_OFF;
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PH_OFF: st_d = tgt;
            PH_TOP: begin
                if (tgt == PH_BOT) begin
                    st_d  = PH_DEAD;
                    cnt_d = '0;
                end else begin
                    st_d = tgt;
                end
            end
            PH_BOT: begin
                if (tgt == PH_TOP) begin
                    st_d  = PH_DEAD;
                    cnt_d = '0;
                end else begin
                    st_d = tgt;
                end
            end
            PH_DEAD: begin
                if (cnt_q == CNT_LAST) st_d = tgt;
                else                   cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        gate_top = 1'b0;
        gate_bot = 1'b0;
        unique case (st_q)
            PH_OFF:  ;
            PH_TOP:  gate_top = 1'b1;
            PH_BOT:  gate_bot = 1'b1;
            PH_DEAD: ;
        endcase
    end
endmodule

// File: rtl/hbg_gate_ctrl.sv
module hbg_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int NUM_PH      = 2,
    parameter int DEAD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] top_cmd,
    input  logic [NUM_PH-1:0] bot_cmd,
    input  logic [NUM_PH-1:0] oc_flag,
    input  logic [1:0]        dis1_mode,
    input  logic              dis2,
    output logic [NUM_PH-1:0] gate_top,
    output logic [NUM_PH-1:0] gate_bot,
    output logic              cl_engaged
);
    localparam int SW = 3 * NUM_PH + 3;

    logic [SW-1:0]     raw_in, syn_in;
    logic [NUM_PH-1:0] top_s, bot_s, oc_s, lat, lim;
    logic [1:0]        dm_s;
    logic              d2_s, dis_all, cl_en;

    assign raw_in = {dis2, dis1_mode, oc_flag, bot_cmd, top_cmd};

    hbg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign top_s   = syn_in[NUM_PH-1:0];
    assign bot_s   = syn_in[2*NUM_PH-1:NUM_PH];
    assign oc_s    = syn_in[3*NUM_PH-1:2*NUM_PH];
    assign dm_s    = syn_in[3*NUM_PH+1:3*NUM_PH];
    assign d2_s    = syn_in[SW-1];
    assign dis_all = dm_s[1] | d2_s;
    assign cl_en   = (dm_s == DIS1_FLOAT);

    for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
        hbg_cl_latch u_lat (
            .clk(clk), .rst_n(rst_n), .cl_en(cl_en), .oc_s(oc_s[g]),
            .top_s(top_s[g]), .latched(lat[g]), .limit_eff(lim[g])
        );
        hbg_phase_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
            .clk(clk), .rst_n(rst_n), .top_s(top_s[g]), .bot_s(bot_s[g]),
            .dis(dis_all), .limit(lim[g]),
            .gate_top(gate_top[g]), .gate_bot(gate_bot[g])
        );
    end

    assign cl_engaged = |lat;
endmodule

// File: rtl/hbg_gate_checker.sv
module hbg_gate_checker #(
    parameter int NUM_PH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] top_cmd,
    input logic [NUM_PH-1:0] bot_cmd,
    input logic [NUM_PH-1:0] oc_flag,
    input logic [1:0]        dis1_mode,
    input logic              dis2,
    input logic [NUM_PH-1:0] gate_top,
    input logic [NUM_PH-1:0] gate_bot,
    input logic              cl_engaged
);
    for (genvar i = 0; i < NUM_PH; i++) begin : g_chk
        assert_no_shoot_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_top[i] && gate_bot[i]));
        assert_dead_tb_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_bot[i]) |-> !$past(gate_top[i]));
        assert_dead_bt_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_top[i]) |-> !$past(gate_bot[i]));
        assert_pair_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(top_cmd[i] && bot_cmd[i], 3) |-> (!gate_top[i] && !gate_bot[i]));
    end

    assert_dis2_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis2, 3) |-> (gate_top == '0 && gate_bot == '0));
    assert_dis1_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis1_mode[1], 3) |-> (gate_top == '0 && gate_bot == '0));
    assert_latch_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cl_engaged) |-> ($past(oc_flag, 3) != '0));
    assert_cl_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis1_mode, 3) == 2'b01) |-> !cl_engaged);
endmodule

bind hbg_gate_ctrl hbg_gate_checker #(.NUM_PH(NUM_PH)) u_hbg_chk (
    .clk(clk), .rst_n(rst_n), .top_cmd(top_cmd), .bot_cmd(bot_cmd),
    .oc_flag(oc_flag), .dis1_mode(dis1_mode), .dis2(dis2),
    .gate_top(gate_top), .gate_bot(gate_bot), .cl_engaged(cl_engaged)
);

// File: tb/hbg_gate_ctrl_bench.sv
module hbg_gate_ctrl_bench;
    localparam int DC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] top_cmd = '0, bot_cmd = '0, oc_flag = '0, dis1_mode = '0;
    logic       dis2 = 1'b0;
    logic [1:0] gate_top, gate_bot;
    logic       cl_engaged;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    hbg_gate_ctrl #(.NUM_PH(2), .DEAD_CYC(DC), .SYNC_STAGES(2)) u_hbg_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .top_cmd(top_cmd), .bot_cmd(bot_cmd),
        .oc_flag(oc_flag), .dis1_mode(dis1_mode), .dis2(dis2),
        .gate_top(gate_top), .gate_bot(gate_bot), .cl_engaged(cl_engaged)
    );

    // behavioural reference: two delay slots for inputs, integer states per phase
    // states: 0 both off, 1 top on, 2 bottom on, 3 dead interval
    logic [8:0] pipe [$];
    int m_st [2], m_cnt [2], m_lat [2], m_tprev [2];

    function automatic logic [8:0] pack_in();
        return {dis2, dis1_mode, oc_flag, bot_cmd, top_cmd};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe = {9'd0, 9'd0};
            for (int p = 0; p < 2; p++) begin
                m_st[p] = 0; m_cnt[p] = 0; m_lat[p] = 0; m_tprev[p] = 0;
            end
        end else begin
            logic [8:0] v;
            int dis, clen, t, b, oc, rise, eff, want;
            v = pipe[0];
            dis  = (v[7] || v[8]) ? 1 : 0;
            clen = (v[7:6] == 2'b00) ? 1 : 0;
            for (int p = 0; p < 2; p++) begin
                t = v[p]; b = v[2+p]; oc = v[4+p];
                rise = (t == 1 && m_tprev[p] == 0) ? 1 : 0;
                eff = (m_lat[p] == 1 && rise == 0) ? 1 : 0;
                if (dis == 1 || (t == 1 && b == 1)) want = 0;
                else if (t == 1) want = (eff == 1) ? 0 : 1;
                else if (b == 1) want = 2;
                else want = 0;
                if (m_st[p] == 3) begin
                    if (m_cnt[p] == DC - 1) m_st[p] = want;
                    else m_cnt[p]++;
                end else if ((m_st[p] == 1 && want == 2) || (m_st[p] == 2 && want == 1)) begin
                    m_st[p] = 3; m_cnt[p] = 0;
                end else begin
                    m_st[p] = want;
                end
                if (clen == 0) m_lat[p] = 0;
                else if (oc == 1) m_lat[p] = 1;
                else if (rise == 1) m_lat[p] = 0;
                m_tprev[p] = t;
            end
            void'(pipe.pop_front());
            pipe.push_back(pack_in());
        end
    end

    task automatic compare_now();
        logic [1:0] et, eb;
        logic ec;
        for (int p = 0; p < 2; p++) begin
            et[p] = (m_st[p] == 1);
            eb[p] = (m_st[p] == 2);
        end
        ec = (m_lat[0] == 1) || (m_lat[1] == 1);
        n_cmp++;
        if (gate_top !== et || gate_bot !== eb || cl_engaged !== ec) begin
            n_bad++;
            $display("FAIL %s: top=%b bot=%b cl=%b expected top=%b bot=%b cl=%b",
                     cur_req, gate_top, gate_bot, cl_engaged, et, eb, ec);
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_now();
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        int first_off, first_on;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(gate_top == 2'b00 && gate_bot == 2'b00 && !cl_engaged, "R10",
            {gate_top, gate_bot, cl_engaged}, 0);
        rst_n = 1'b1;
        run(2);

        // R1 top-only on phase 0 and bottom-only on phase 1
        cur_req = "R1";
        top_cmd = 2'b01; bot_cmd = 2'b10;
        run(2);
        chk(gate_top == 2'b00 && gate_bot == 2'b00, "R1", {gate_top, gate_bot}, 0);
        run(1);
        chk(gate_top == 2'b01 && gate_bot == 2'b10, "R1", {gate_top, gate_bot}, 4'b0110);
        run(3);

        // R2 both high on phase 0
        cur_req = "R2";
        bot_cmd = 2'b11;
        run(5);
        chk(gate_top[0] == 0 && gate_bot[0] == 0, "R2", {gate_top[0], gate_bot[0]}, 0);

        // R3 both low
        cur_req = "R3";
        top_cmd = 2'b00; bot_cmd = 2'b00;
        run(5);
        chk(gate_top == 0 && gate_bot == 0, "R3", {gate_top, gate_bot}, 0);

        // R4 simultaneous swap top->bottom on phase 0
        cur_req = "R4";
        top_cmd = 2'b01;
        run(6);
        top_cmd = 2'b00; bot_cmd = 2'b01;
        first_off = 0; first_on = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            compare_now();
            if (first_off == 0 && !gate_top[0]) first_off = k;
            if (first_on == 0 && gate_bot[0]) first_on = k;
        end
        chk(first_off == 3, "R4", first_off, 3);
        chk(first_on == 3 + DC, "R4", first_on, 3 + DC);

        // R4 swap bottom->top
        top_cmd = 2'b01; bot_cmd = 2'b00;
        first_on = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            compare_now();
            if (first_on == 0 && gate_top[0]) first_on = k;
        end
        chk(first_on == 3 + DC, "R4", first_on, 3 + DC);

        // R4 non-simultaneous: one both-low cycle, no dead interval
        top_cmd = 2'b00;
        run(1);
        bot_cmd = 2'b01;
        first_on = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            compare_now();
            if (first_on == 0 && gate_bot[0]) first_on = k;
        end
        chk(first_on == 3, "R4", first_on, 3);

        // R5 second disable
        cur_req = "R5";
        top_cmd = 2'b10; bot_cmd = 2'b01;
        run(5);
        dis2 = 1'b1;
        run(5);
        chk(gate_top == 0 && gate_bot == 0, "R5", {gate_top, gate_bot}, 0);
        dis2 = 1'b0;
        run(5);
        chk(gate_top == 2'b10 && gate_bot == 2'b01, "R5", {gate_top, gate_bot}, 4'b1001);

        // R6 first line driven high, both codes
        cur_req = "R6";
        dis1_mode = 2'b10;
        run(5);
        chk(gate_top == 0 && gate_bot == 0, "R6", {gate_top, gate_bot}, 0);
        dis1_mode = 2'b11;
        run(5);
        chk(gate_top == 0 && gate_bot == 0, "R6", {gate_top, gate_bot}, 0);
        dis1_mode = 2'b00;
        run(5);

        // R7 current-limit latch on phase 0, phase 1 keeps running
        cur_req = "R7";
        top_cmd = 2'b11; bot_cmd = 2'b00;
        run(5);
        oc_flag = 2'b01;
        run(1);
        oc_flag = 2'b00;
        run(5);
        chk(gate_top == 2'b10 && cl_engaged, "R7", {gate_top, cl_engaged}, 3'b101);

        // R8 clear on next top rising edge
        cur_req = "R8";
        top_cmd = 2'b10;
        run(3);
        top_cmd = 2'b11;
        run(5);
        chk(gate_top == 2'b11 && !cl_engaged, "R8", {gate_top, cl_engaged}, 3'b110);

        // R8 flag coinciding with the top rising edge: latch stays engaged
        top_cmd = 2'b10;
        run(4);
        top_cmd = 2'b11; oc_flag = 2'b01;
        run(1);
        oc_flag = 2'b00;
        run(6);
        chk(gate_top[0] == 0 && cl_engaged, "R8", {gate_top[0], cl_engaged}, 2'b01);

        // R9 current limit turned off: latch cleared, flag ignored
        cur_req = "R9";
        dis1_mode = 2'b01;
        run(4);
        oc_flag = 2'b11;
        run(2);
        oc_flag = 2'b00;
        run(5);
        chk(gate_top == 2'b11 && !cl_engaged, "R9", {gate_top, cl_engaged}, 3'b110);

        // R4 with R5 in the same cycle: swap arrives together with a disable
        cur_req = "R4";
        dis1_mode = 2'b00;
        top_cmd = 2'b01; bot_cmd = 2'b00;
        run(5);
        top_cmd = 2'b00; bot_cmd = 2'b01; dis2 = 1'b1;
        run(4);
        chk(gate_top == 0 && gate_bot == 0, "R5", {gate_top, gate_bot}, 0);
        dis2 = 1'b0;
        run(DC + 6);
        chk(gate_bot[0] == 1, "R4", gate_bot[0], 1);

        cur_req = "R11";
        top_cmd = 2'b00; bot_cmd = 2'b00;
        run(6);
        finish_up();
    end
endmodule